// File: doc/BRIEF.md
# Flag Offset Register Loader

This block holds the two offset values, X and Y, that a FIFO's programmable almost-empty and almost-full comparators use. Each is `W` bits wide. The loading method is fixed while master reset is held. At that time the block samples a mode input and two select inputs. Together they choose one of three preset offsets (8, 16 or 64), a parallel load of two words from the write port, or a serial load of one bit per write-clock edge.

The two select inputs have a second role. After reset, in serial mode, `sel1_sen_n` becomes an active-low shift enable and `sel0_sdi` becomes the serial data bit. The serial stream fills the register pair Y:X starting at the most significant bit of Y and ending at the least significant bit of X. Once the offsets are complete, `done` rises and holds. From then until the next master reset, any further load activity is ignored.

A FIFO partial reset is not wired to this block, so a partial reset leaves the chosen method and the loaded offsets untouched. The master reset `rst_n` is asserted asynchronously. Its release is synchronised inside the block, which takes two write-clock edges.

Top module: `flo_loader`

## Requirements
- R1: With `prog_mode` low and {`sel1_sen_n`,`sel0_sdi`} = 00 during reset, both offsets read 8 after reset release.
- R2: With `prog_mode` low and {`sel1_sen_n`,`sel0_sdi`} = 01 during reset, both offsets read 16.
- R3: With `prog_mode` low and `sel1_sen_n` high during reset (either value of `sel0_sdi`), both offsets read 64.
- R4: In preset mode, `done` is high from the third write-clock edge after `rst_n` rises.
- R5: In serial mode (`prog_mode` high, `sel0_sdi` high during reset), every rising edge with `sel1_sen_n` low shifts `sel0_sdi` into Y:X. The first bit lands in Y's MSB and the bit of the 2*W-th enabled edge lands in X's LSB. `done` rises after that edge and not before.
- R6: In serial mode, an edge with `sel1_sen_n` high changes neither offset.
- R7: Once `done` is high, further serial enables or load strobes leave both offsets unchanged, and `done` stays high until master reset.
- R8: In parallel mode (`prog_mode` high, `sel0_sdi` low during reset), the first edge with `ld_stb` high loads X from `ld_data[W-1:0]`. The second such edge loads Y from the same bits and raises `done`.
- R9: In parallel mode serial enables are ignored, and in serial mode load strobes are ignored.
- R10: Changes on `prog_mode` and the select inputs after reset release do not change the chosen method.
- R11: In serial and parallel modes, both offsets read zero and `done` is low right after reset release until loading completes.
- R12: `done` is low while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| prog_mode | input | 1 | Method class sampled during reset: 1 = serial/parallel, 0 = preset |
| sel1_sen_n | input | 1 | Preset select bit 1 during reset; active-low serial enable afterwards |
| sel0_sdi | input | 1 | Preset select bit 0 / serial-vs-parallel choice during reset; serial data afterwards |
| ld_stb | input | 1 | Parallel load strobe |
| ld_data | input | DW | Write-port word for parallel load |
| x_off | output | W | X offset value |
| y_off | output | W | Y offset value |
| done | output | 1 | Offsets fully loaded |

## Verification
A wrong method latch appears at the ports on the first load attempt. The offsets take a preset value when they should stay at zero, or a shift lands where a strobe was expected. This shows within one edge of the first stimulus. A counter that is off by one appears as `done` rising one enabled edge early or late, or as the final bit landing one place away from X's LSB. So the bench samples `done` just before the last serial bit and again just after it. A missing freeze after completion appears as a changed offset one edge after an extra enable, and the bench probes for this right after `done` rises.

// File: rtl/flo_pkg.sv
package flo_pkg;

  typedef enum logic [1:0] {
    M_PRESET = 2'd0,
    M_PAR    = 2'd1,
    M_SER    = 2'd2
  } meth_e;

  function automatic meth_e decode_meth(input logic mode, input logic s0);
    if (!mode) return M_PRESET;
    return s0 ? M_SER : M_PAR;
  endfunction

  function automatic logic [6:0] preset_val(input logic s1, input logic s0);
    if (s1) return 7'd64;
    return s0 ? 7'd16 : 7'd8;
  endfunction

endpackage

// File: rtl/flo_rst_sync.sv
module flo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_sync_n = q2;
endmodule

// File: rtl/flo_cfg.sv
module flo_cfg
  import flo_pkg::*;
(
  input  logic  clk,
  input  logic  cap,
  input  logic  mode,
  input  logic  s0,
  output meth_e meth
);
  meth_e meth_d;

  always_comb begin
    meth_d = meth;
    if (cap) meth_d = decode_meth(mode, s0);
  end

  always_ff @(posedge clk) begin
    meth <= meth_d;
  end
endmodule

// File: rtl/flo_count.sv
module flo_count #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] target,
  output logic [CW-1:0] cnt,
  output logic          full
);
  logic [CW-1:0] cnt_d;

  assign full = (cnt == target);

  always_comb begin
    cnt_d = cnt;
    if (clr)              cnt_d = '0;
    else if (inc && !full) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R5: the bit/word count never passes the configured total
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n || clr)
    cnt <= target);
endmodule

// File: rtl/flo_loader.sv
module flo_loader
  import flo_pkg::*;
#(
  parameter int W  = 10,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_mode,
  input  logic          sel1_sen_n,
  input  logic          sel0_sdi,
  input  logic          ld_stb,
  input  logic [DW-1:0] ld_data,
  output logic [W-1:0]  x_off,
  output logic [W-1:0]  y_off,
  output logic          done
);
  localparam int YXW = 2 * W;
  localparam int CW  = $clog2(YXW + 1);

  logic            rst_sync_n;
  meth_e           meth;
  logic [CW-1:0]   cnt, target;
  logic            full, ser_go, par_go;
  logic [YXW-1:0]  yx, yx_d;
  logic [6:0]      pv;

  initial begin
    if (W < 7)   $error("W must hold the largest preset");
    if (DW < W)  $error("DW must cover W");
  end

  flo_rst_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  flo_cfg u_cfg (
    .clk  (clk),
    .cap  (!rst_sync_n),
    .mode (prog_mode),
    .s0   (sel0_sdi),
    .meth (meth)
  );

  always_comb begin
    case (meth)
      M_SER:   target = CW'(YXW);
      M_PAR:   target = CW'(2);
      default: target = '0;
    endcase
  end

  assign ser_go = rst_sync_n && (meth == M_SER) && !full && !sel1_sen_n;
  assign par_go = rst_sync_n && (meth == M_PAR) && !full && ld_stb;

  flo_count #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!rst_sync_n),
    .inc    (ser_go || par_go),
    .target (target),
    .cnt    (cnt),
    .full   (full)
  );

  assign pv = preset_val(sel1_sen_n, sel0_sdi);

  always_comb begin
    yx_d = yx;
    if (!rst_sync_n) begin
      if (prog_mode) yx_d = '0;
      else           yx_d = {W'(pv), W'(pv)};
    end else if (ser_go) begin
      yx_d = {yx[YXW-2:0], sel0_sdi};
    end else if (par_go) begin
      if (cnt[0]) yx_d[YXW-1:W] = ld_data[W-1:0];
      else        yx_d[W-1:0]   = ld_data[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) yx <= '0;
    else        yx <= yx_d;
  end

  assign y_off = yx[YXW-1:W];
  assign x_off = yx[W-1:0];
  assign done  = rst_sync_n && full;

  // R7: completion holds until master reset
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> done);
  // R7: offsets frozen once complete
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> $stable({y_off, x_off}));
  // R10: method fixed after reset release
  p_cfg_fixed_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> $stable(meth));
  // R5: an enabled serial edge puts the data bit in X's LSB
  p_serial_shift_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ser_go |=> x_off[0] == $past(sel0_sdi));
  // R4: preset method reports done out of reset
  p_preset_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && meth == M_PRESET) |-> done);
  // R8: first parallel strobe fills X
  p_par_x_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (par_go && cnt == '0) |=> x_off == $past(ld_data[W-1:0]));
endmodule

// File: tb/flo_loader_bench.sv
module flo_loader_bench;
  localparam int W  = 10;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n, prog_mode, sel1_sen_n, sel0_sdi, ld_stb;
  logic [DW-1:0] ld_data;
  logic [W-1:0]  x_off, y_off;
  logic          done;
  int            n_chk = 0, n_fail = 0;
  bit            finished = 1'b0;

  always #5 clk = ~clk;

  flo_loader #(.W(W), .DW(DW)) u_flo_loader (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .sel1_sen_n(sel1_sen_n),
    .sel0_sdi(sel0_sdi), .ld_stb(ld_stb), .ld_data(ld_data),
    .x_off(x_off), .y_off(y_off), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic s1, input logic s0);
    @(negedge clk);
    rst_n = 1'b0; prog_mode = m; sel1_sen_n = s1; sel0_sdi = s0;
    ld_stb = 1'b0; ld_data = '0;
    repeat (4) @(negedge clk);
    chk("R12", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic ser_edge(input logic en, input logic b);
    sel1_sen_n = !en; sel0_sdi = b;
    @(negedge clk);
    sel1_sen_n = 1'b1;
  endtask

  task automatic strobe(input logic [DW-1:0] d);
    ld_stb = 1'b1; ld_data = d;
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic t_presets();
    do_reset(1'b0, 1'b0, 1'b0);
    chk("R1", "x preset 8", int'(x_off), 8);
    chk("R1", "y preset 8", int'(y_off), 8);
    chk("R4", "done preset", int'(done), 1);
    do_reset(1'b0, 1'b0, 1'b1);
    chk("R2", "x preset 16", int'(x_off), 16);
    chk("R2", "y preset 16", int'(y_off), 16);
    do_reset(1'b0, 1'b1, 1'b0);
    chk("R3", "x preset 64 (10)", int'(x_off), 64);
    do_reset(1'b0, 1'b1, 1'b1);
    chk("R3", "y preset 64 (11)", int'(y_off), 64);
    chk("R4", "done preset 64", int'(done), 1);
  endtask

  task automatic t_cfg_locked();
    do_reset(1'b0, 1'b0, 1'b1);
    prog_mode = 1'b1;
    for (int i = 0; i < 4; i++) ser_edge(1'b1, 1'b1);
    strobe(36'h0_0000_03FF);
    chk("R10", "x after late select change", int'(x_off), 16);
    chk("R10", "y after late select change", int'(y_off), 16);
    chk("R10", "done kept", int'(done), 1);
  endtask

  task automatic t_serial();
    logic [2*W-1:0] pat = 20'hB3C5A;
    do_reset(1'b1, 1'b1, 1'b1);
    chk("R11", "serial x at start", int'(x_off), 0);
    chk("R11", "serial done at start", int'(done), 0);
    strobe(36'h0_0000_0155);
    chk("R9", "strobe ignored in serial", int'({y_off, x_off}), 0);
    for (int i = 0; i < W; i++) ser_edge(1'b1, pat[2*W-1-i]);
    chk("R5", "x after half stream", int'(x_off), int'(pat[2*W-1:W]));
    chk("R5", "y after half stream", int'(y_off), 0);
    ser_edge(1'b0, !pat[W-1]);
    chk("R6", "disabled edge x", int'(x_off), int'(pat[2*W-1:W]));
    for (int i = W; i < 2*W-1; i++) ser_edge(1'b1, pat[2*W-1-i]);
    chk("R5", "done before last bit", int'(done), 0);
    ser_edge(1'b1, pat[0]);
    chk("R5", "y after stream", int'(y_off), int'(pat[2*W-1:W]));
    chk("R5", "x after stream", int'(x_off), int'(pat[W-1:0]));
    chk("R5", "done after stream", int'(done), 1);
    for (int i = 0; i < 3; i++) ser_edge(1'b1, !pat[0]);
    chk("R7", "x after extra bits", int'(x_off), int'(pat[W-1:0]));
    chk("R7", "done held", int'(done), 1);
  endtask

  task automatic t_parallel();
    do_reset(1'b1, 1'b1, 1'b0);
    chk("R11", "parallel y at start", int'(y_off), 0);
    ser_edge(1'b1, 1'b1);
    chk("R9", "serial ignored in parallel", int'({y_off, x_off}), 0);
    strobe(36'hF_ABCD_E2A5);
    chk("R8", "x from first word", int'(x_off), 'h2A5);
    chk("R8", "y still zero", int'(y_off), 0);
    chk("R8", "done after one word", int'(done), 0);
    strobe(36'h3_0000_0137);
    chk("R8", "y from second word", int'(y_off), 'h137);
    chk("R8", "done after two words", int'(done), 1);
    strobe(36'h0_0000_0001);
    chk("R7", "x after extra strobe", int'(x_off), 'h2A5);
    chk("R7", "y after extra strobe", int'(y_off), 'h137);
  endtask

  initial begin
    rst_n = 1'b0; prog_mode = 1'b0; sel1_sen_n = 1'b1; sel0_sdi = 1'b0;
    ld_stb = 1'b0; ld_data = '0;
    t_presets();
    t_cfg_locked();
    t_serial();
    t_parallel();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule